// File: doc/BRIEF.md
# Serial Wiper Setting Port

This block is the digital control port of a dual 8-bit wiper controller. A host drives three serial lines into it: an active-high transaction enable, a serial clock and a data line. While the enable is high, each rising serial-clock edge shifts one data bit into a 17-bit frame register. When the enable drops, the frame is copied into the active settings. These are two wiper codes and a stack-select flag that steers the mux for the stacked output.

The oldest stage of the frame register always drives a cascade output. Several ports can therefore be daisy-chained, with each cascade output feeding the next data input. Wiring the last cascade output back to the first data input gives a readback that does not destroy the settings.

The three serial lines are asynchronous to the core clock `clk`. Each line passes through a synchronizer with a parameterized number of stages. Serial-clock and enable edges are then detected in the core clock domain. All state changes happen on `clk`.

Top module: `pot_serial_ctrl`

## Requirements
- R1: While `reset` is high and on the cycle after it, `wiper0` and `wiper1` read 8'h80, `stack_sel` reads 0, `out_sel` reads 2'b01 and `cascade_out` reads 0. The frame register also holds stack 0 and both codes at 8'h80.
- R2: While `rst_en` is high, every rising edge of `clk_ser` shifts the level on `dq` into the frame register.
- R3: Rising edges of `clk_ser` while `rst_en` is low are ignored. No shift occurs, `cascade_out` keeps its value and the active settings do not change.
- R4: After the enable falls, the active settings come from the last 17 bits shifted in. The oldest of those bits is `stack_sel`. The next eight bits form `wiper1`, MSB first. The final eight bits form `wiper0`, MSB first.
- R5: `wiper0`, `wiper1` and `stack_sel` change only when `rst_en` falls. Shifting alone never alters them.
- R6: `cascade_out` always presents the oldest bit of the frame register, whatever the level of `rst_en`. Each shift therefore exposes the bit that entered 16 shifts earlier.
- R7: If `cascade_out` is fed back to `dq` and exactly 17 bits are clocked, the frame returns to its prior contents. Ending the transaction then reloads unchanged settings.
- R8: A transfer of fewer than 17 bits leaves the frame partly shifted, and that partial frame is still loaded when the enable falls.
- R9: `out_sel` is 2'b01 (stacked mux takes wiper 0) when `stack_sel` is 0, and 2'b10 (takes wiper 1) when `stack_sel` is 1.
- R10: The frame register is never cleared between transactions. In a transfer of 34 bits, only the last 17 define the loaded settings.
- R11: An enable pulse with no serial-clock edges reloads the current frame contents into the active settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| reset | input | 1 | Synchronous active-high initialization |
| rst_en | input | 1 | Serial transaction enable, active high, asynchronous |
| clk_ser | input | 1 | Serial shift clock, asynchronous |
| dq | input | 1 | Serial data input |
| cascade_out | output | 1 | Oldest frame bit, feeds the next port in a chain |
| wiper0 | output | 8 | Active code of wiper 0 |
| wiper1 | output | 8 | Active code of wiper 1 |
| stack_sel | output | 1 | Active stack-select flag |
| out_sel | output | 2 | One-hot select for the stacked wiper mux |

## Verification
Several properties are checked on every cycle. The active settings hold unless an enable fall was detected. A load copies the frame with the field order of R4. A shift moves the next-oldest frame bit onto `cascade_out`, and without a shift `cascade_out` holds. `out_sel` is kept one-hot and in step with `stack_sel`.

Other behaviours span whole transactions, and only the bench's scenarios can show them. These are the end-to-end frame ordering at the pins, the loopback restore, partial and double-length transfers, ignored clocks while idle, and enable pulses without clocks. The bench compares all of them against its own bit-level model of the frame.

// File: rtl/pot_pkg.sv
package pot_pkg;
    localparam int DEF_WIPER_W    = 8;
    localparam int DEF_SYNC_DEPTH = 2;
    localparam int LINE_CNT       = 3;
    localparam int LINE_DQ        = 0;
    localparam int LINE_SCLK      = 1;
    localparam int LINE_EN        = 2;

    typedef enum logic [1:0] {
        SEL_WIPER0 = 2'b01,
        SEL_WIPER1 = 2'b10
    } stack_mux_e;
endpackage

// File: rtl/pot_sync.sv
module pot_sync #(
    parameter int N     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         reset,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [DEPTH-1:0][N-1:0] pipe;
        logic [N-1:0]            prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = raw;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.prev = st_q.pipe[DEPTH-1];
    end

    always_ff @(posedge clk) begin
        if (reset) st_q <= '0;
        else       st_q <= st_d;
    end

    assign level = st_q.pipe[DEPTH-1];
    assign rise  = level & ~st_q.prev;
    assign fall  = ~level & st_q.prev;
endmodule

// File: rtl/pot_shift.sv
module pot_shift #(
    parameter int                 FW   = 17,
    parameter logic [FW-1:0]      INIT = '0
) (
    input  logic          clk,
    input  logic          reset,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [FW-1:0] frame,
    output logic          cascade_out
);
    typedef struct packed {
        logic [FW-1:0] sr;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[FW-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (reset) st_q.sr <= INIT;
        else       st_q    <= st_d;
    end

    assign frame       = st_q.sr;
    assign cascade_out = st_q.sr[FW-1];
endmodule

// File: rtl/pot_active.sv
module pot_active #(
    parameter int                WW      = 8,
    parameter logic [WW-1:0]     RST_VAL = 8'h80,
    localparam int               FW      = 2 * WW + 1
) (
    input  logic          clk,
    input  logic          reset,
    input  logic          load,
    input  logic [FW-1:0] frame,
    output logic [WW-1:0] wiper0,
    output logic [WW-1:0] wiper1,
    output logic          stack_sel,
    output logic [1:0]    out_sel
);
    import pot_pkg::*;

    typedef struct packed {
        logic          stack;
        logic [WW-1:0] w1;
        logic [WW-1:0] w0;
    } active_t;

    active_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.stack = frame[FW-1];
            st_d.w1    = frame[FW-2 -: WW];
            st_d.w0    = frame[WW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (reset) begin
            st_q.stack <= 1'b0;
            st_q.w1    <= RST_VAL;
            st_q.w0    <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    stack_mux_e sel;
    always_comb sel = st_q.stack ? SEL_WIPER1 : SEL_WIPER0;

    assign wiper0    = st_q.w0;
    assign wiper1    = st_q.w1;
    assign stack_sel = st_q.stack;
    assign out_sel   = sel;
endmodule

// File: rtl/pot_serial_ctrl.sv
module pot_serial_ctrl #(
    parameter int             WIPER_W    = pot_pkg::DEF_WIPER_W,
    parameter int             SYNC_DEPTH = pot_pkg::DEF_SYNC_DEPTH,
    parameter logic [WIPER_W-1:0] RST_WIPER = 8'h80,
    localparam int            FRAME_W    = 2 * WIPER_W + 1
) (
    input  logic               clk,
    input  logic               reset,
    input  logic               rst_en,
    input  logic               clk_ser,
    input  logic               dq,
    output logic               cascade_out,
    output logic [WIPER_W-1:0] wiper0,
    output logic [WIPER_W-1:0] wiper1,
    output logic               stack_sel,
    output logic [1:0]         out_sel
);
    import pot_pkg::*;

    localparam logic [FRAME_W-1:0] FRAME_INIT = {1'b0, RST_WIPER, RST_WIPER};

    logic [LINE_CNT-1:0] line_lvl, line_rise, line_fall;
    logic                shift_w, load_w;
    logic [FRAME_W-1:0]  frame_w;

    pot_sync #(.N(LINE_CNT), .DEPTH(SYNC_DEPTH)) i_sync (
        .clk   (clk),
        .reset (reset),
        .raw   ({rst_en, clk_ser, dq}),
        .level (line_lvl),
        .rise  (line_rise),
        .fall  (line_fall)
    );

    assign shift_w = line_rise[LINE_SCLK] & line_lvl[LINE_EN];
    assign load_w  = line_fall[LINE_EN];

    pot_shift #(.FW(FRAME_W), .INIT(FRAME_INIT)) i_shift (
        .clk         (clk),
        .reset       (reset),
        .shift_en    (shift_w),
        .bit_in      (line_lvl[LINE_DQ]),
        .frame       (frame_w),
        .cascade_out (cascade_out)
    );

    pot_active #(.WW(WIPER_W), .RST_VAL(RST_WIPER)) i_active (
        .clk       (clk),
        .reset     (reset),
        .load      (load_w),
        .frame     (frame_w),
        .wiper0    (wiper0),
        .wiper1    (wiper1),
        .stack_sel (stack_sel),
        .out_sel   (out_sel)
    );
endmodule

// File: rtl/pot_serial_ctrl_chk.sv
module pot_serial_ctrl_chk #(
    parameter int             WIPER_W   = 8,
    parameter logic [WIPER_W-1:0] RST_WIPER = 8'h80,
    localparam int            FRAME_W   = 2 * WIPER_W + 1
) (
    input logic               clk,
    input logic               reset,
    input logic               shift_w,
    input logic               load_w,
    input logic [FRAME_W-1:0] frame_w,
    input logic               cascade_out,
    input logic [WIPER_W-1:0] wiper0,
    input logic [WIPER_W-1:0] wiper1,
    input logic               stack_sel,
    input logic [1:0]         out_sel
);
    a_r1_reset_value: assert property (@(posedge clk)
        reset |=> (wiper0 == RST_WIPER) && (wiper1 == RST_WIPER) && !stack_sel && !cascade_out);

    a_r5_hold_without_load: assert property (@(posedge clk) disable iff (reset)
        !load_w |=> $stable(wiper0) && $stable(wiper1) && $stable(stack_sel));

    a_r4_load_order: assert property (@(posedge clk) disable iff (reset)
        load_w |=> {stack_sel, wiper1, wiper0} == $past(frame_w));

    a_r6_cascade_next: assert property (@(posedge clk) disable iff (reset)
        shift_w |=> cascade_out == $past(frame_w[FRAME_W-2]));

    a_r3_cascade_idle: assert property (@(posedge clk) disable iff (reset)
        !shift_w |=> $stable(cascade_out));

    a_r9_mux_select: assert property (@(posedge clk) disable iff (reset)
        load_w |=> $onehot(out_sel) && (out_sel[1] == $past(frame_w[FRAME_W-1])));
endmodule

bind pot_serial_ctrl pot_serial_ctrl_chk #(.WIPER_W(WIPER_W), .RST_WIPER(RST_WIPER)) i_chk (
    .clk         (clk),
    .reset       (reset),
    .shift_w     (shift_w),
    .load_w      (load_w),
    .frame_w     (frame_w),
    .cascade_out (cascade_out),
    .wiper0      (wiper0),
    .wiper1      (wiper1),
    .stack_sel   (stack_sel),
    .out_sel     (out_sel)
);

// File: tb/test_pot_serial_ctrl.sv
module test_pot_serial_ctrl;
    logic       clk = 1'b0;
    logic       reset = 1'b1;
    logic       rst_en = 1'b0;
    logic       clk_ser = 1'b0;
    logic       dq = 1'b0;
    logic       cascade_out;
    logic [7:0] wiper0, wiper1;
    logic       stack_sel;
    logic [1:0] out_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [16:0] m;           // bench model of frame, bit 16 = oldest
    logic [7:0]  e_w0, e_w1;
    logic        e_st;

    always #2.5 clk = ~clk;

    pot_serial_ctrl i_pot_serial_ctrl (
        .clk(clk), .reset(reset), .rst_en(rst_en), .clk_ser(clk_ser), .dq(dq),
        .cascade_out(cascade_out), .wiper0(wiper0), .wiper1(wiper1),
        .stack_sel(stack_sel), .out_sel(out_sel)
    );

    function automatic logic [16:0] pack_frame(logic s, logic [7:0] a1, logic [7:0] a0);
        return {s, a1, a0};
    endfunction

    function automatic logic [1:0] exp_sel(logic s);
        return s ? 2'b10 : 2'b01;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic check_active(string req);
        check({wiper0, wiper1, stack_sel} == {e_w0, e_w1, e_st}, req,
              {15'd0, wiper0, wiper1, stack_sel}, {15'd0, e_w0, e_w1, e_st});
        check(out_sel == exp_sel(e_st), {req, "/R9"}, {30'd0, out_sel}, {30'd0, exp_sel(e_st)});
    endtask

    task automatic enable_on();
        rst_en = 1'b1;
        settle();
    endtask

    task automatic enable_off(string req);
        rst_en = 1'b0;
        settle();
        e_st = m[16];
        e_w1 = m[15:8];
        e_w0 = m[7:0];
        check_active(req);
    endtask

    task automatic clock_bit(logic b, string req);
        dq = b;
        settle();
        clk_ser = 1'b1;
        settle();
        if (rst_en) m = {m[15:0], b};
        clk_ser = 1'b0;
        settle();
        check(cascade_out == m[16], {req, "/R6"}, {31'd0, cascade_out}, {31'd0, m[16]});
        check_active({req, "/R5"});
    endtask

    task automatic send_frame(logic [16:0] f, string req);
        for (int i = 16; i >= 0; i--) clock_bit(f[i], req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        m = pack_frame(1'b0, 8'h80, 8'h80);
        e_w0 = 8'h80; e_w1 = 8'h80; e_st = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state while reset is held and after release
        check_active("R1");
        check(cascade_out == 1'b0, "R1", {31'd0, cascade_out}, 32'd0);
        reset = 1'b0;
        settle();
        check_active("R1");

        // R4 and R9: full write with stack 1
        enable_on();
        send_frame(pack_frame(1'b1, 8'hA5, 8'h3C), "R2");
        enable_off("R4");
        check(wiper1 == 8'hA5 && wiper0 == 8'h3C && stack_sel, "R4",
              {15'd0, wiper0, wiper1, stack_sel}, {15'd0, 8'h3C, 8'hA5, 1'b1});
        check(out_sel == 2'b10, "R9", {30'd0, out_sel}, 32'd2);

        // R3: clocks while enable is low are ignored
        for (int i = 0; i < 5; i++) clock_bit(i[0], "R3");
        enable_on();
        enable_off("R3");

        // R7: loopback restores frame
        enable_on();
        for (int i = 0; i < 17; i++) clock_bit(cascade_out, "R7");
        enable_off("R7");
        check(wiper1 == 8'hA5 && wiper0 == 8'h3C && stack_sel, "R7",
              {15'd0, wiper0, wiper1, stack_sel}, {15'd0, 8'h3C, 8'hA5, 1'b1});

        // R8: short transfer of 5 bits
        enable_on();
        for (int i = 0; i < 5; i++) clock_bit(1'b1, "R8");
        enable_off("R8");

        // R10: double-length transfer keeps last 17 bits
        enable_on();
        send_frame(pack_frame(1'b1, 8'h11, 8'h22), "R10");
        send_frame(pack_frame(1'b0, 8'hC3, 8'h5A), "R10");
        enable_off("R10");
        check(wiper1 == 8'hC3 && wiper0 == 8'h5A && !stack_sel && out_sel == 2'b01, "R10",
              {13'd0, out_sel, wiper0, wiper1, stack_sel}, {13'd0, 2'b01, 8'h5A, 8'hC3, 1'b0});

        // R11: enable pulse without clocks
        enable_on();
        enable_off("R11");

        // Random transactions with a fixed seed
        void'($urandom(32'h5EED_1234));
        for (int t = 0; t < 30; t++) begin
            int len;
            bit loop;
            len  = 1 + int'($urandom % 36);
            loop = ($urandom % 4) == 0;
            if (loop) len = 17;
            enable_on();
            for (int i = 0; i < len; i++) begin
                if (loop) clock_bit(cascade_out, "R7");
                else      clock_bit(1'($urandom), "R2");
            end
            enable_off("R4");
            if ($urandom % 3 == 0) clock_bit(1'($urandom), "R3");
        end

        finish_run();
    end
endmodule